// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the storage stage of one programmable-logic macrocell, built for a fabric that runs on a single fast system clock. Configuration inputs choose how the single state bit behaves. It can be an edge-triggered D, T, JK or SR element, or a level-sensitive transparent latch. Configuration also chooses where its data comes from, which of two macrocell clocks drives it, whether a product-term clock enable gates the global clock, and which sources can force it to 0 or 1.

The macrocell clocks (`gclk`, `pt_clk`) are data-rate signals sampled on the system clock `clk`. A rising edge is found by comparing each sample with the previous one. Clear and preset act on the next system-clock edge, with no macrocell clock edge needed. This reproduces the asynchronous behaviour between macrocell edges without using a second clock domain.

An output stage registers three values: the pin value, the feedback value and the output enable. The pin and feedback each take either the stored bit or the combinatorial XOR result, and each makes that choice on its own. The enable is picked from six sources.

Top module: `mcell_reg`

## Requirements
- R1: While `rst` is 1 at a `clk` edge, the stored bit and all three outputs become 0, and the edge detectors forget previous clock samples (both are taken as 0).
- R2: With `cfg_mode` = 0 (D), the stored bit takes the data value only on a detected rising edge of the selected clock. Levels, falling edges and data changes while the clock is held leave it unchanged.
- R3: On a rising edge, `cfg_mode` = 1 (T) toggles when data is 1. Mode 2 (JK, J = data, K = `pt_k`) holds on 00, clears on 01, sets on 10 and toggles on 11. Mode 3 (SR, S = data, R = `pt_k`) holds on 00, clears on 01, sets on 10 and holds on 11. Modes 5 to 7 act as D.
- R4: With `cfg_mode` = 4 (latch), the stored bit follows data while the selected clock is 1 and holds while it is 0.
- R5: `cfg_dsel` picks the data: 0 = `xor_in`, 1 = `pt_data`, 2 = `pin_in`, 3 = `xor_in`.
- R6: `cfg_csel` = 0 selects `gclk` and 1 selects `pt_clk`. With `gclk` selected and `cfg_ce_en` = 1, a rising edge while `pt_ce` = 0 is ignored. With `pt_clk` selected, `pt_ce` has no effect.
- R7: `cfg_clr_sel` picks the clear: 0 = never, 1 = `gclr`, 2 = `pt_clr`, 3 = either. An active clear forces the bit to 0 without a clock edge and wins over preset.
- R8: With `cfg_pre_en` = 1, `pt_pre` = 1 forces the bit to 1 without a clock edge, unless a clear is active. With `cfg_pre_en` = 0, `pt_pre` has no effect.
- R9: `pin_o` carries the new stored bit when `cfg_out_reg` = 1 and `xor_in` when it is 0.
- R10: `fb_o` carries the new stored bit when `cfg_fb_reg` = 1 and `xor_in` when it is 0, whatever the pin choice.
- R11: `cfg_oe_sel` picks `oe_o`: 0 = off, 1 = on, 2 = `oe_a`, 3 = `oe_b`, 4 = `oe_pin`, 5 = `pt_oe`, 6 and 7 = off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Storage mode |
| cfg_dsel | input | 2 | Data source select |
| cfg_csel | input | 1 | Macrocell clock select |
| cfg_ce_en | input | 1 | Use product-term clock enable with global clock |
| cfg_clr_sel | input | 2 | Clear source select |
| cfg_pre_en | input | 1 | Enable product-term preset |
| cfg_out_reg | input | 1 | Pin takes stored bit (1) or XOR result (0) |
| cfg_fb_reg | input | 1 | Feedback takes stored bit (1) or XOR result (0) |
| cfg_oe_sel | input | 3 | Output enable source select |
| gclk | input | 1 | Global macrocell clock sample |
| pt_clk | input | 1 | Product-term clock |
| pt_ce | input | 1 | Product-term clock enable |
| gclr | input | 1 | Global clear |
| pt_clr | input | 1 | Product-term clear |
| pt_pre | input | 1 | Product-term preset |
| xor_in | input | 1 | XOR gate result |
| pt_data | input | 1 | Separate data product term |
| pt_k | input | 1 | Second operand (K or R) |
| pin_in | input | 1 | Pin input value |
| oe_a | input | 1 | First dedicated enable input |
| oe_b | input | 1 | Second dedicated enable input |
| oe_pin | input | 1 | Enable from a pin used as input |
| pt_oe | input | 1 | Product-term enable |
| pin_o | output | 1 | Registered pin value |
| fb_o | output | 1 | Registered feedback value |
| oe_o | output | 1 | Registered output enable |

## Verification
Every result is due on the first `clk` edge that samples the stimulus. The three outputs are registered from the next-state value, so they change on that same edge. The stored bit, a clear or preset, the enable, and the combinatorial XOR path all share this one-cycle latency. The driver applies each stimulus on a falling edge and queues the expected outputs. The monitor pops one entry two time units after each rising edge, so every comparison matches a stimulus with the edge that captured it.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    DSEL_XOR = 2'd0,
    DSEL_PT  = 2'd1,
    DSEL_PIN = 2'd2
  } dsel_e;

  typedef enum logic [2:0] {
    OE_OFF = 3'd0,
    OE_ON  = 3'd1,
    OE_A   = 3'd2,
    OE_B   = 3'd3,
    OE_PIN = 3'd4,
    OE_PT  = 3'd5
  } oe_e;

  localparam int MODE_W = 3;
  localparam int DSEL_W = 2;
  localparam int CLR_W  = 2;
  localparam int OE_W   = 3;
endpackage

// File: rtl/mcell_src_sel.sv
module mcell_src_sel
  import mcell_pkg::*;
#(
  parameter int DW = DSEL_W,
  parameter int CW = CLR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cfg_dsel,
  input  logic          cfg_csel,
  input  logic          cfg_ce_en,
  input  logic [CW-1:0] cfg_clr_sel,
  input  logic          cfg_pre_en,
  input  logic          gclk,
  input  logic          pt_clk,
  input  logic          pt_ce,
  input  logic          gclr,
  input  logic          pt_clr,
  input  logic          pt_pre,
  input  logic          xor_in,
  input  logic          pt_data,
  input  logic          pin_in,
  output logic          din,
  output logic          clk_lvl,
  output logic          clk_fire,
  output logic          clr_act,
  output logic          pre_act
);
  logic gclk_q, ptclk_q;
  logic g_rise, p_rise, ce_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      gclk_q  <= 1'b0;
      ptclk_q <= 1'b0;
    end else begin
      gclk_q  <= gclk;
      ptclk_q <= pt_clk;
    end
  end

  always_comb begin
    case (cfg_dsel)
      DSEL_PT:  din = pt_data;
      DSEL_PIN: din = pin_in;
      default:  din = xor_in;
    endcase
  end

  assign g_rise   = gclk & ~gclk_q;
  assign p_rise   = pt_clk & ~ptclk_q;
  assign ce_ok    = ~cfg_ce_en | pt_ce;
  assign clk_lvl  = cfg_csel ? pt_clk : gclk;
  assign clk_fire = cfg_csel ? p_rise : (g_rise & ce_ok);
  assign clr_act  = (cfg_clr_sel[0] & gclr) | (cfg_clr_sel[1] & pt_clr);
  assign pre_act  = cfg_pre_en & pt_pre;

  // R6: a disabled global clock must not produce a capture
  assert_ce_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_csel && cfg_ce_en && !pt_ce) |-> !clk_fire);

  // R6: a held product-term clock never fires twice in a row
  assert_single_fire_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_csel && clk_fire && $stable(cfg_csel)) |=> (!clk_fire || !$stable(cfg_csel)));
endmodule

// File: rtl/mcell_next_state.sv
module mcell_next_state
  import mcell_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic [MW-1:0] cfg_mode,
  input  logic          q,
  input  logic          din,
  input  logic          kin,
  input  logic          clk_lvl,
  input  logic          clk_fire,
  input  logic          clr_act,
  input  logic          pre_act,
  output logic          q_next
);
  logic edge_val;

  always_comb begin
    case (cfg_mode)
      MODE_T:  edge_val = q ^ din;
      MODE_JK: begin
        case ({din, kin})
          2'b01:   edge_val = 1'b0;
          2'b10:   edge_val = 1'b1;
          2'b11:   edge_val = ~q;
          default: edge_val = q;
        endcase
      end
      MODE_SR: begin
        case ({din, kin})
          2'b01:   edge_val = 1'b0;
          2'b10:   edge_val = 1'b1;
          default: edge_val = q;
        endcase
      end
      default: edge_val = din;
    endcase
  end

  always_comb begin
    if (clr_act)                  q_next = 1'b0;
    else if (pre_act)             q_next = 1'b1;
    else if (cfg_mode == MODE_LATCH) q_next = clk_lvl ? din : q;
    else if (clk_fire)            q_next = edge_val;
    else                          q_next = q;
  end
endmodule

// File: rtl/mcell_out_stage.sv
module mcell_out_stage
  import mcell_pkg::*;
#(
  parameter int OW = OE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_out_reg,
  input  logic          cfg_fb_reg,
  input  logic [OW-1:0] cfg_oe_sel,
  input  logic          q_next,
  input  logic          comb_in,
  input  logic          oe_a,
  input  logic          oe_b,
  input  logic          oe_pin,
  input  logic          pt_oe,
  output logic          pin_o,
  output logic          fb_o,
  output logic          oe_o
);
  logic oe_d;

  always_comb begin
    case (cfg_oe_sel)
      OE_ON:   oe_d = 1'b1;
      OE_A:    oe_d = oe_a;
      OE_B:    oe_d = oe_b;
      OE_PIN:  oe_d = oe_pin;
      OE_PT:   oe_d = pt_oe;
      default: oe_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o <= 1'b0;
      fb_o  <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      pin_o <= cfg_out_reg ? q_next : comb_in;
      fb_o  <= cfg_fb_reg  ? q_next : comb_in;
      oe_o  <= oe_d;
    end
  end

  // R11: disabled buffer stays off
  assert_oe_off_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_oe_sel == OE_OFF) |=> !oe_o);

  // R11: permanently enabled buffer stays on
  assert_oe_on_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_oe_sel == OE_ON) |=> oe_o);

  // R9 R10: matching selections give matching pin and feedback
  assert_fb_match_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_out_reg == cfg_fb_reg) |=> (pin_o == fb_o));
endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_pkg::*;
#(
  parameter int  MW       = MODE_W,
  parameter int  DW       = DSEL_W,
  parameter int  CW       = CLR_W,
  parameter int  OW       = OE_W,
  parameter bit  INIT_VAL = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] cfg_mode,
  input  logic [DW-1:0] cfg_dsel,
  input  logic          cfg_csel,
  input  logic          cfg_ce_en,
  input  logic [CW-1:0] cfg_clr_sel,
  input  logic          cfg_pre_en,
  input  logic          cfg_out_reg,
  input  logic          cfg_fb_reg,
  input  logic [OW-1:0] cfg_oe_sel,
  input  logic          gclk,
  input  logic          pt_clk,
  input  logic          pt_ce,
  input  logic          gclr,
  input  logic          pt_clr,
  input  logic          pt_pre,
  input  logic          xor_in,
  input  logic          pt_data,
  input  logic          pt_k,
  input  logic          pin_in,
  input  logic          oe_a,
  input  logic          oe_b,
  input  logic          oe_pin,
  input  logic          pt_oe,
  output logic          pin_o,
  output logic          fb_o,
  output logic          oe_o
);
  logic din, clk_lvl, clk_fire, clr_act, pre_act;
  logic state_q, state_d;

  mcell_src_sel #(.DW(DW), .CW(CW)) u_src (
    .clk(clk), .rst(rst),
    .cfg_dsel(cfg_dsel), .cfg_csel(cfg_csel), .cfg_ce_en(cfg_ce_en),
    .cfg_clr_sel(cfg_clr_sel), .cfg_pre_en(cfg_pre_en),
    .gclk(gclk), .pt_clk(pt_clk), .pt_ce(pt_ce),
    .gclr(gclr), .pt_clr(pt_clr), .pt_pre(pt_pre),
    .xor_in(xor_in), .pt_data(pt_data), .pin_in(pin_in),
    .din(din), .clk_lvl(clk_lvl), .clk_fire(clk_fire),
    .clr_act(clr_act), .pre_act(pre_act)
  );

  mcell_next_state #(.MW(MW)) u_ns (
    .cfg_mode(cfg_mode), .q(state_q), .din(din), .kin(pt_k),
    .clk_lvl(clk_lvl), .clk_fire(clk_fire),
    .clr_act(clr_act), .pre_act(pre_act), .q_next(state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= INIT_VAL;
    else     state_q <= state_d;
  end

  mcell_out_stage #(.OW(OW)) u_out (
    .clk(clk), .rst(rst),
    .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg), .cfg_oe_sel(cfg_oe_sel),
    .q_next(state_d), .comb_in(xor_in),
    .oe_a(oe_a), .oe_b(oe_b), .oe_pin(oe_pin), .pt_oe(pt_oe),
    .pin_o(pin_o), .fb_o(fb_o), .oe_o(oe_o)
  );

  // R7: an active clear leaves the bit at 0 one cycle later
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> !state_q);

  // R8: preset without clear leaves the bit at 1
  assert_preset_R8: assert property (@(posedge clk) disable iff (rst)
    (pre_act && !clr_act) |=> state_q);

  // R2: edge modes hold without a fired edge or forcing control
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode != MODE_LATCH && !clk_fire && !clr_act && !pre_act) |=> $stable(state_q));

  // R9: registered pin mirrors the stored bit
  assert_pin_reg_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_out_reg |=> (pin_o == state_q));
endmodule

// File: tb/mcell_reg_test.sv
module mcell_reg_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [2:0] cfg_mode = 3'd0;
  logic [1:0] cfg_dsel = 2'd0;
  logic cfg_csel = 0, cfg_ce_en = 0;
  logic [1:0] cfg_clr_sel = 2'd0;
  logic cfg_pre_en = 0, cfg_out_reg = 1, cfg_fb_reg = 1;
  logic [2:0] cfg_oe_sel = 3'd1;
  logic gclk = 0, pt_clk = 0, pt_ce = 0, gclr = 0, pt_clr = 0, pt_pre = 0;
  logic xor_in = 0, pt_data = 0, pt_k = 0, pin_in = 0;
  logic oe_a = 0, oe_b = 0, oe_pin = 0, pt_oe = 0;
  logic pin_o, fb_o, oe_o;

  mcell_reg uut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_dsel(cfg_dsel),
    .cfg_csel(cfg_csel), .cfg_ce_en(cfg_ce_en), .cfg_clr_sel(cfg_clr_sel),
    .cfg_pre_en(cfg_pre_en), .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg),
    .cfg_oe_sel(cfg_oe_sel), .gclk(gclk), .pt_clk(pt_clk), .pt_ce(pt_ce),
    .gclr(gclr), .pt_clr(pt_clr), .pt_pre(pt_pre), .xor_in(xor_in),
    .pt_data(pt_data), .pt_k(pt_k), .pin_in(pin_in), .oe_a(oe_a), .oe_b(oe_b),
    .oe_pin(oe_pin), .pt_oe(pt_oe), .pin_o(pin_o), .fb_o(fb_o), .oe_o(oe_o)
  );

  typedef struct {
    logic  pin;
    logic  fb;
    logic  oe;
    string req;
  } exp_t;

  exp_t sb[$];
  int checks = 0, failures = 0;
  bit finished = 0;
  bit m_q = 0, m_g = 0, m_p = 0;

  task automatic drive(input string req);
    exp_t e;
    bit d, lvl, rise, cl, pr, nq;
    if (rst) begin
      nq = 0; m_g = 0; m_p = 0;
      e.pin = 0; e.fb = 0; e.oe = 0;
    end else begin
      d = (cfg_dsel == 2'd1) ? pt_data : (cfg_dsel == 2'd2) ? pin_in : xor_in;
      lvl = cfg_csel ? pt_clk : gclk;
      rise = cfg_csel ? (pt_clk && !m_p) : (gclk && !m_g && (!cfg_ce_en || pt_ce));
      cl = (cfg_clr_sel[0] && gclr) || (cfg_clr_sel[1] && pt_clr);
      pr = cfg_pre_en && pt_pre;
      if (cl) nq = 0;
      else if (pr) nq = 1;
      else if (cfg_mode == 3'd4) nq = lvl ? d : m_q;
      else if (!rise) nq = m_q;
      else case (cfg_mode)
        3'd1: nq = d ? !m_q : m_q;
        3'd2: nq = (d && pt_k) ? !m_q : (d ? 1'b1 : (pt_k ? 1'b0 : m_q));
        3'd3: nq = (d && !pt_k) ? 1'b1 : ((!d && pt_k) ? 1'b0 : m_q);
        default: nq = d;
      endcase
      m_g = gclk; m_p = pt_clk;
      e.pin = cfg_out_reg ? nq : xor_in;
      e.fb  = cfg_fb_reg ? nq : xor_in;
      case (cfg_oe_sel)
        3'd1: e.oe = 1; 3'd2: e.oe = oe_a; 3'd3: e.oe = oe_b;
        3'd4: e.oe = oe_pin; 3'd5: e.oe = pt_oe; default: e.oe = 0;
      endcase
    end
    m_q = nq;
    e.req = req;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic gpulse(input string req);
    gclk = 1; drive(req);
    gclk = 0; drive(req);
  endtask

  task automatic ppulse(input string req);
    pt_clk = 1; drive(req);
    pt_clk = 0; drive(req);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pin_o !== e.pin || fb_o !== e.fb || oe_o !== e.oe) begin
        failures++;
        $display("FAIL %s: pin/fb/oe actual %b%b%b expected %b%b%b",
                 e.req, pin_o, fb_o, oe_o, e.pin, e.fb, e.oe);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state with inputs active
    xor_in = 1; pt_pre = 1; gclk = 1;
    drive("R1"); drive("R1");
    rst = 0; pt_pre = 0; gclk = 0; xor_in = 0;
    drive("R1");

    // R2: D mode from XOR, edges and held levels
    cfg_mode = 3'd0; cfg_dsel = 2'd0;
    xor_in = 1; gpulse("R2");
    gclk = 1; drive("R2"); xor_in = 0; drive("R2"); drive("R2");
    gclk = 0; drive("R2");
    gpulse("R2");
    xor_in = 1; drive("R2");

    // R5: data source select
    for (int s = 0; s < 4; s++) begin
      cfg_dsel = s[1:0];
      xor_in = (s == 0 || s == 3); pt_data = (s == 1); pin_in = (s == 2);
      gpulse("R5");
      xor_in = !xor_in; pt_data = !pt_data; pin_in = !pin_in;
      gpulse("R5");
    end
    cfg_dsel = 2'd1;

    // R3: T, JK, SR tables
    cfg_mode = 3'd1;
    pt_data = 1; gpulse("R3"); gpulse("R3");
    pt_data = 0; gpulse("R3");
    pt_data = 1; gpulse("R3");
    for (int m = 2; m <= 3; m++) begin
      cfg_mode = m[2:0];
      for (int c = 0; c < 8; c++) begin
        pt_data = c[1]; pt_k = c[0];
        gpulse("R3");
      end
    end
    cfg_mode = 3'd6; pt_data = 0; gpulse("R3"); pt_data = 1; gpulse("R3");
    pt_k = 0;

    // R4: latch mode on both clock sources
    cfg_mode = 3'd4;
    for (int cs = 0; cs < 2; cs++) begin
      cfg_csel = cs[0];
      pt_data = 0; drive("R4");
      if (cs == 0) gclk = 1; else pt_clk = 1;
      pt_data = 1; drive("R4"); pt_data = 0; drive("R4"); pt_data = 1; drive("R4");
      gclk = 0; pt_clk = 0;
      pt_data = 0; drive("R4"); drive("R4");
    end

    // R6: clock select and enable
    cfg_mode = 3'd0; cfg_csel = 0; cfg_ce_en = 1;
    pt_data = 1; pt_ce = 0; gpulse("R6");
    pt_ce = 1; gpulse("R6");
    pt_data = 0; pt_ce = 0; gpulse("R6");
    cfg_csel = 1; gpulse("R6"); ppulse("R6");
    pt_data = 1; ppulse("R6");
    cfg_ce_en = 0; cfg_csel = 0; pt_data = 0; gpulse("R6");

    // R7: clear sources and priority
    pt_data = 1; gpulse("R7");
    for (int c = 0; c < 4; c++) begin
      cfg_clr_sel = c[1:0]; cfg_pre_en = 1;
      gclr = 1; drive("R7"); gclr = 0; pt_pre = 1; drive("R7"); pt_pre = 0;
      pt_clr = 1; drive("R7"); pt_clr = 0; pt_pre = 1; drive("R7"); pt_pre = 0;
    end
    cfg_clr_sel = 2'd3; gclr = 1; pt_pre = 1; drive("R7"); drive("R7");
    gclr = 0; drive("R7"); pt_pre = 0;

    // R8: preset enable off
    cfg_clr_sel = 2'd0; cfg_pre_en = 0;
    pt_data = 0; gpulse("R8");
    pt_pre = 1; drive("R8"); pt_pre = 0; drive("R8");
    cfg_pre_en = 1; pt_pre = 1; drive("R8"); pt_pre = 0; drive("R8");

    // R9 R10: independent pin and feedback choice
    for (int o = 0; o < 4; o++) begin
      cfg_out_reg = o[1]; cfg_fb_reg = o[0];
      xor_in = 0; drive(o[1] ? "R9" : "R10");
      xor_in = 1; drive("R10");
      pt_data = !pt_data; gpulse("R9");
    end
    cfg_out_reg = 1; cfg_fb_reg = 1;

    // R11: enable sources
    for (int s = 0; s < 8; s++) begin
      cfg_oe_sel = s[2:0];
      oe_a = 1; oe_b = 0; oe_pin = 1; pt_oe = 0; drive("R11");
      oe_a = 0; oe_b = 1; oe_pin = 0; pt_oe = 1; drive("R11");
    end

    // R1: reset mid-operation
    cfg_oe_sel = 3'd1; pt_data = 1; gpulse("R1");
    rst = 1; gclk = 1; drive("R1");
    rst = 0; drive("R1"); gclk = 0; drive("R1");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule